// File: doc/BRIEF.md
# Scatter-Gather Translation Buffer

This block is a small, fully associative translation cache for the target side of a PCI-to-host bridge. A PCI access that has already been decoded into a scatter-gather window is presented as a dword address and a flag that says whether it arrived as a 64-bit dual-address cycle (DAC). Each entry covers one 32KB PCI page. It holds the tag, the DAC flag and four 20-bit host page numbers, one for each 8KB quarter of that page. Each quarter has its own valid bit. A hit returns the host dword address one cycle after the lookup is accepted.

When a lookup misses, the block picks a victim entry. It scans round-robin from a rotating pointer and skips locked entries. It then raises a fill request that names the tag, the DAC flag and the victim slot, and stalls further lookups until the external page-table walker delivers four page numbers and their quarter-valid bits. If every entry is locked, the miss is reported as an error and no fill is requested. An invalidate-all strobe drops every translation in one cycle and keeps the locks. A lock port sets or clears the lock of one slot at a time.

Top module: `sg_xlat_buffer`

## Requirements
- R1: After reset no translation is valid, so every lookup misses. The response and fill-request outputs are low, `lk_ready` is high and the round-robin pointer is at slot 0.
- R2: A lookup hits only when an entry's tag equals `lk_addr[31:15]` and that entry's valid bit for quarter `lk_addr[14:13]` is set. When several entries qualify, the lowest-numbered slot is used.
- R3: On a hit, `rsp_paddr[32:13]` is the page number of the selected quarter, `rsp_paddr[12:2]` equals `lk_addr[12:2]` and `rsp_paddr[1:0]` is zero.
- R4: `rsp_valid` is high in exactly the cycle after a lookup is accepted (`lk_valid` and `lk_ready` both high) and low otherwise.
- R5: A miss with at least one unlocked slot raises `fill_req` in the next cycle. `fill_tag` is the missed `lk_addr[31:15]` and `fill_dac` is the missed DAC flag. `fill_req` stays high until a cycle with `fill_valid`, after which it is low and `lk_ready` is high.
- R6: A fill writes the victim slot. Quarter k gets page number `fill_ppn[20k+19:20k]` and valid bit `fill_sv[k]`, and the stored tag and DAC flag are those of the miss.
- R7: The victim is the first unlocked slot at or after the round-robin pointer, scanning upward with wrap. `fill_way` shows the victim. After the fill, the pointer moves to the slot after the victim.
- R8: A miss while all slots are locked gives `rsp_err` high with `rsp_hit` low. No fill is requested and `lk_ready` stays high.
- R9: `inv_all` clears every quarter-valid bit at the next edge. Lookups accepted afterwards miss, and lock bits are kept.
- R10: While a fill is pending, `lk_ready` is low and `lk_valid` is ignored: no response is produced for it.
- R11: `lock_wr` writes `lock_val` into the lock bit of slot `lock_sel`. Locked slots still hit but are never chosen as victims.
- R12: An entry hits only when its stored DAC flag equals `lk_dac`. The same tag and quarter with the other flag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted (no fill pending) |
| lk_addr | input | 30 | PCI dword address, bits 31:2 |
| lk_dac | input | 1 | Access arrived as a dual-address cycle |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_err | output | 1 | Miss with every slot locked |
| rsp_paddr | output | 33 | Host byte address of the dword on a hit |
| fill_req | output | 1 | Page-table fill requested |
| fill_tag | output | 17 | 32KB PCI page of the missed access |
| fill_dac | output | 1 | DAC flag of the missed access |
| fill_way | output | 3 | Slot that the fill will overwrite |
| fill_valid | input | 1 | Fill data delivered |
| fill_ppn | input | 80 | Four 20-bit host page numbers, quarter 0 lowest |
| fill_sv | input | 4 | Valid bit for each quarter |
| inv_all | input | 1 | Invalidate every translation |
| lock_wr | input | 1 | Write one lock bit |
| lock_sel | input | 3 | Slot whose lock bit is written |
| lock_val | input | 1 | New lock value |

## Verification
A corrupted tag, DAC flag or quarter-valid bit shows up on the first later lookup of that page. That lookup returns the wrong `rsp_hit`, and if it falsely misses, a fill request appears one cycle later. A wrong stored page number shows in `rsp_paddr[32:13]` on that same response. A drifting round-robin pointer or a lost lock bit is visible on the next miss through `fill_way`. A stuck pending flag shows at once as `lk_ready` staying low or `fill_req` staying high after the fill cycle.

// File: rtl/sgtb_pkg.sv
// Package: shared widths and the entry record of the scatter-gather
// translation buffer. Assumes a 32-bit PCI address space with 32KB tag
// pages, 8KB host pages and a 33-bit host byte address.
package sgtb_pkg;
    localparam int TAG_W   = 17;   // PCI address bits 31:15
    localparam int SUBPG   = 4;    // 8KB quarters per 32KB page
    localparam int SUB_W   = 2;    // PCI address bits 14:13
    localparam int OFS_W   = 11;   // PCI address bits 12:2
    localparam int PPN_W   = 20;   // host address bits 32:13
    localparam int PA_W    = PPN_W + OFS_W + 2;

    typedef struct packed {
        logic [TAG_W-1:0]             tag;
        logic                         dac;
        logic [SUBPG-1:0]             sv;
        logic [SUBPG-1:0][PPN_W-1:0]  ppn;
    } sgtb_entry_t;
endpackage

// File: rtl/sgtb_tag_match.sv
// Module: parallel tag compare over all slots plus a lowest-index
// priority pick. Assumes ENTRIES >= 2. Purely combinational.
module sgtb_tag_match
    import sgtb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  sgtb_entry_t        ents [ENTRIES],
    input  logic [TAG_W-1:0]   tag,
    input  logic               dac,
    input  logic [SUB_W-1:0]   sub,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    // One comparator per slot: tag, cycle type and selected quarter valid.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].sv[sub] && (ents[g].tag == tag) && (ents[g].dac == dac);
    end

    // Lowest-numbered matching slot wins.
    always_comb begin
        hit_any = |hit_vec;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sgtb_rr_pick.sv
// Module: round-robin victim choice. Scans upward from the pointer with
// wrap and returns the first slot whose lock bit is clear. found is low
// when every slot is locked. Purely combinational.
module sgtb_rr_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] locked,
    input  logic [IDX_W-1:0]   ptr,
    output logic               found,
    output logic [IDX_W-1:0]   victim
);
    int idx;

    // Descending scan so the smallest offset from ptr is assigned last.
    always_comb begin
        found  = 1'b0;
        victim = '0;
        idx    = 0;
        for (int off = ENTRIES - 1; off >= 0; off--) begin
            idx = (int'(ptr) + off) % ENTRIES;
            if (!locked[idx]) begin
                found  = 1'b1;
                victim = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/sg_xlat_buffer.sv
// Module: fully associative scatter-gather translation buffer.
// Each slot holds one 32KB PCI page tag, a DAC flag and four 8KB host page
// numbers with per-quarter valid bits. Lookups answer one cycle after
// acceptance. A miss latches a victim and stalls lookups until fill_valid.
// Assumes window decode and DAC base checks are done upstream, and that
// ENTRIES is at least 2.
module sg_xlat_buffer
    import sgtb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    output logic                    lk_ready,
    input  logic [31:2]             lk_addr,
    input  logic                    lk_dac,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_err,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic                    fill_req,
    output logic [TAG_W-1:0]        fill_tag,
    output logic                    fill_dac,
    output logic [IDX_W-1:0]        fill_way,
    input  logic                    fill_valid,
    input  logic [SUBPG*PPN_W-1:0]  fill_ppn,
    input  logic [SUBPG-1:0]        fill_sv,
    input  logic                    inv_all,
    input  logic                    lock_wr,
    input  logic [IDX_W-1:0]        lock_sel,
    input  logic                    lock_val
);
    sgtb_entry_t        ent_q [ENTRIES];
    logic [ENTRIES-1:0] lock_q;
    logic [IDX_W-1:0]   rr_ptr_q;
    logic               pend_q;
    logic [IDX_W-1:0]   pend_way_q;
    logic [TAG_W-1:0]   pend_tag_q;
    logic               pend_dac_q;

    logic               accept;
    logic               fill_done;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic               vic_found;
    logic [IDX_W-1:0]   vic_idx;
    logic [TAG_W-1:0]   lk_tag;
    logic [SUB_W-1:0]   lk_sub;

    assign lk_tag    = lk_addr[31:15];
    assign lk_sub    = lk_addr[14:13];
    assign lk_ready  = !pend_q;
    assign accept    = lk_valid && !pend_q;
    assign fill_done = fill_valid && pend_q;
    assign fill_req  = pend_q;
    assign fill_tag  = pend_tag_q;
    assign fill_dac  = pend_dac_q;
    assign fill_way  = pend_way_q;

    sgtb_tag_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ent_q),
        .tag     (lk_tag),
        .dac     (lk_dac),
        .sub     (lk_sub),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    sgtb_rr_pick #(.ENTRIES(ENTRIES)) u_pick (
        .locked (lock_q),
        .ptr    (rr_ptr_q),
        .found  (vic_found),
        .victim (vic_idx)
    );

    // Register the lookup result for the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && hit_any;
            rsp_err   <= accept && !hit_any && !vic_found;
            rsp_paddr <= (accept && hit_any)
                       ? {ent_q[hit_idx].ppn[lk_sub], lk_addr[12:2], 2'b00}
                       : '0;
        end
    end

    // Track an outstanding fill and the slot it will overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_way_q <= '0;
            pend_tag_q <= '0;
            pend_dac_q <= 1'b0;
        end else if (fill_done) begin
            pend_q     <= 1'b0;
        end else if (accept && !hit_any && vic_found) begin
            pend_q     <= 1'b1;
            pend_way_q <= vic_idx;
            pend_tag_q <= lk_tag;
            pend_dac_q <= lk_dac;
        end
    end

    // Advance the round-robin pointer past each replaced slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (fill_done) begin
            rr_ptr_q <= (pend_way_q == IDX_W'(ENTRIES - 1)) ? '0 : pend_way_q + 1'b1;
        end
    end

    // Per-slot lock bits, written one at a time, untouched by invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_wr) begin
            lock_q[lock_sel] <= lock_val;
        end
    end

    // Slot storage: fill writes the victim, invalidate drops all quarters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_done && (pend_way_q == IDX_W'(i))) begin
                    ent_q[i].tag <= pend_tag_q;
                    ent_q[i].dac <= pend_dac_q;
                    ent_q[i].ppn <= fill_ppn;
                    ent_q[i].sv  <= inv_all ? '0 : fill_sv;
                end else if (inv_all) begin
                    ent_q[i].sv  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sgtb_checker.sv
// Module: port-level protocol checks for sg_xlat_buffer, attached by bind.
module sgtb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic [31:2] lk_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_err,
    input logic [32:0] rsp_paddr,
    input logic        fill_req,
    input logic        fill_valid,
    input logic        inv_all
);
    // R4: an accepted lookup answers in the next cycle.
    assert_rsp_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    // R10: a lookup offered during a pending fill produces no response.
    assert_stall_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> !rsp_valid);

    // R3: hit address keeps the dword offset and is dword aligned.
    assert_paddr_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[1:0] == 2'b00) && (rsp_paddr[12:2] == $past(lk_addr[12:2])));

    // R8: a no-victim error is a miss and never opens a fill.
    assert_err_no_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid && !rsp_hit && !fill_req);

    // R5: a pending fill persists until data arrives, then clears.
    assert_fill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> fill_req);
    assert_fill_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |=> (!fill_req && lk_ready));

    // R9: a lookup accepted right after invalidate-all cannot hit.
    assert_inv_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all) && lk_valid && lk_ready) |=> !rsp_hit);
endmodule

bind sg_xlat_buffer sgtb_checker u_sgtb_checker (.*);

// File: tb/tb_sg_xlat_buffer.sv
`timescale 1ns/1ps
module tb_sg_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:2] lk_addr = '0;
    logic        lk_dac = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_err;
    logic [32:0] rsp_paddr;
    logic        fill_req;
    logic [16:0] fill_tag;
    logic        fill_dac;
    logic [2:0]  fill_way;
    logic        fill_valid = 1'b0;
    logic [79:0] fill_ppn = '0;
    logic [3:0]  fill_sv = '0;
    logic        inv_all = 1'b0;
    logic        lock_wr = 1'b0;
    logic [2:0]  lock_sel = '0;
    logic        lock_val = 1'b0;

    int checks = 0;
    int errors = 0;
    int seq = 0;

    // Reference state kept from the requirements.
    logic [16:0] m_tag [8];
    logic        m_dac [8];
    logic [3:0]  m_sv [8];
    logic [19:0] m_ppn [8][4];
    logic        m_lock [8];
    int          m_ptr = 0;

    always #5 clk = ~clk;

    sg_xlat_buffer dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:2] mk_addr(input logic [16:0] t, input int sub, input int ofs);
        return {t, 2'(sub), 11'(ofs)};
    endfunction

    task automatic do_lookup(input logic [31:2] a, input bit d, input string lbl);
        int  hi = -1;
        int  vi = -1;
        int  sub = int'(a[14:13]);
        logic [32:0] exp_pa;
        for (int i = 7; i >= 0; i--)
            if (m_sv[i][sub] && m_tag[i] == a[31:15] && m_dac[i] == d) hi = i;
        for (int off = 7; off >= 0; off--)
            if (!m_lock[(m_ptr + off) % 8]) vi = (m_ptr + off) % 8;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_dac = d;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R4", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_hit == (hi >= 0), lbl, "rsp_hit", 64'(rsp_hit), 64'(hi >= 0));
        if (hi >= 0) begin
            exp_pa = {m_ppn[hi][sub], a[12:2], 2'b00};
            chk(rsp_paddr == exp_pa, "R3", "rsp_paddr", 64'(rsp_paddr), 64'(exp_pa));
        end else if (vi < 0) begin
            chk(rsp_err == 1'b1, "R8", "rsp_err", 64'(rsp_err), 64'd1);
            chk(fill_req == 1'b0 && lk_ready == 1'b1, "R8", "fill_req/lk_ready",
                64'({fill_req, lk_ready}), 64'b01);
        end else begin
            chk(rsp_err == 1'b0, "R8", "rsp_err on miss", 64'(rsp_err), 64'd0);
            chk(fill_req == 1'b1, "R5", "fill_req", 64'(fill_req), 64'd1);
            chk(fill_tag == a[31:15] && fill_dac == d, "R5", "fill_tag/dac",
                64'({fill_tag, fill_dac}), 64'({a[31:15], d}));
            chk(fill_way == 3'(vi), "R7 R11", "fill_way", 64'(fill_way), 64'(vi));
            // Offer another lookup while the fill is outstanding.
            lk_valid = 1'b1; lk_addr = a ^ 30'h2000;
            @(negedge clk);
            lk_valid = 1'b0;
            chk(rsp_valid == 1'b0 && lk_ready == 1'b0, "R10", "stalled lookup",
                64'({rsp_valid, lk_ready}), 64'b00);
            seq++;
            for (int k = 0; k < 4; k++) fill_ppn[k*20 +: 20] = 20'(seq * 97 + k * 13 + 5);
            fill_sv = (seq % 3 == 1) ? 4'b0101 : 4'b1111;
            fill_valid = 1'b1;
            @(negedge clk);
            fill_valid = 1'b0;
            chk(fill_req == 1'b0 && lk_ready == 1'b1, "R5", "fill release",
                64'({fill_req, lk_ready}), 64'b01);
            m_tag[vi] = a[31:15];
            m_dac[vi] = d;
            m_sv[vi]  = fill_sv;
            for (int k = 0; k < 4; k++) m_ppn[vi][k] = fill_ppn[k*20 +: 20];
            m_ptr = (vi + 1) % 8;
        end
    endtask

    task automatic set_lock(input int idx, input bit v);
        @(negedge clk);
        lock_wr = 1'b1; lock_sel = 3'(idx); lock_val = v;
        @(negedge clk);
        lock_wr = 1'b0;
        m_lock[idx] = v;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_tag[i] = '0; m_dac[i] = 1'b0; m_sv[i] = '0; m_lock[i] = 1'b0;
            for (int k = 0; k < 4; k++) m_ppn[i][k] = '0;
        end
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0 && fill_req == 0 && lk_ready == 1, "R1", "reset outputs",
            64'({rsp_valid, fill_req, lk_ready}), 64'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // Empty buffer: every lookup misses; fills go to slots 0..7 in turn.
        for (int i = 0; i < 8; i++)
            do_lookup(mk_addr(17'(16'h100 + i * 3), i % 4, i * 77), i[0], "R1");

        // Sweep every slot, quarter and cycle type.
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 4; k++)
                for (int d = 0; d < 2; d++)
                    do_lookup(mk_addr(17'(16'h100 + i * 3), k, (i * 4 + k) * 13),
                              d[0], (d == (i % 2)) ? "R2 R6" : "R12");

        // Locked slots are skipped as victims yet still hit.
        set_lock(1, 1'b1); set_lock(2, 1'b1); set_lock(5, 1'b1);
        for (int n = 0; n < 6; n++)
            do_lookup(mk_addr(17'(16'h1000 + n), n % 4, n * 5), 1'b0, "R11");
        for (int i = 0; i < 8; i++)
            do_lookup(mk_addr(m_tag[i], 0, 3), m_dac[i], "R11");

        // Every slot locked: the miss is reported as an error.
        for (int i = 0; i < 8; i++) set_lock(i, 1'b1);
        do_lookup(mk_addr(17'h1F000, 1, 9), 1'b0, "R8");
        set_lock(0, 1'b0); set_lock(3, 1'b0);

        // Invalidate all: prior pages miss, locks still steer the victims.
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        for (int i = 0; i < 8; i++) m_sv[i] = '0;
        for (int i = 0; i < 8; i++)
            do_lookup(mk_addr(m_tag[i], i % 4, i), m_dac[i], "R9");
        chk(m_ptr == 1 || m_ptr == 4, "R9", "victims limited to unlocked slots",
            64'(m_ptr), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule